// File: doc/BRIEF.md
# Serial Register Access Master

This block is the host side of a four-wire configuration bus. A client hands it register write and read requests over a valid/ready command port. The block turns each request into a sixteen-bit serial frame. It generates the serial clock and the active-low chip select itself, at a rate divided down from the system clock. Read results come back on a one-cycle response port.

The slave answers a read one frame late. During the first eight clocks of every frame it shifts out the register that the previous frame addressed. After a read frame, the master therefore owes the bus a second frame to collect the byte. When another command is already waiting, that command is sent as the collecting frame. When nothing is waiting, the master sends a read of the same address. That extra read does not itself create a further collection. Between frames the chip select stays high for a programmable minimum number of system clocks.

Top module: `regbus_master`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, the command port is ready and no response is valid.
- R2: A frame is sent MSB first as {direction, device bit, address[5:0], data[7:0]}. Direction is 0 for a write and 1 for a read. The device bit is always 0. The data field is the write data for a write and all zeros for a read.
- R3: The data output changes only while the serial clock is low, so the slave captures every frame bit correctly on the rising edge.
- R4: A read completes after two frames. The response carries the read address and the byte captured MSB first at the first eight rising edges of the frame that follows the read frame.
- R5: When no command is waiting at the moment a collection is owed, the master sends a read of the same address with a zero data field. That frame creates no further collection, and no further frames follow.
- R6: When a command is waiting while a collection is owed, that command is sent as the collecting frame, and its own effect (for example a register write) still takes place.
- R7: The serial clock is low whenever chip select is high. Inside a frame, each low half and each high half lasts exactly max(half_div_i,1) system clocks.
- R8: Between two frames, chip select stays high for at least max(gap_i,1) system clocks. When the next frame is ready to go, it stays high for exactly that many clocks.
- R9: The command port is not ready while a frame is in progress or while the minimum chip-select gap has not yet elapsed.
- R10: A response is valid for exactly one cycle, starting in the cycle in which chip select returns high at the end of the collecting frame.
- R11: A write that is not followed by a collection produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_div_i | input | DIV_W | System clocks per serial-clock half period (0 acts as 1) |
| gap_i | input | GAP_W | Minimum chip-select-high clocks between frames (0 acts as 1) |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Command accepted this cycle when valid is high |
| cmd_rd_i | input | 1 | 1 for a read, 0 for a write |
| cmd_addr_i | input | 6 | Register address |
| cmd_wdata_i | input | 8 | Write data (ignored for reads) |
| rsp_valid_o | output | 1 | Read response strobe |
| rsp_addr_o | output | 6 | Address of the read being answered |
| rsp_data_o | output | 8 | Returned register byte |
| ser_clk_o | output | 1 | Serial clock, idles low |
| ser_cs_n_o | output | 1 | Active-low chip select |
| ser_mosi_o | output | 1 | Serial data to the slave |
| ser_miso_i | input | 1 | Serial data from the slave |

## Verification
The bench keeps the default counter widths (DIV_W = 8, GAP_W = 8) and changes the run-time divider and gap between scenarios. It uses half periods of 1, 2 and 4 clocks and gaps of 0, 3 and 7. The zero gap exercises the "acts as 1" rule, and the one-clock divider covers the fastest toggle, where every tick flips the clock. A behavioural slave model has register contents that vary with the address. Single reads, a read overlapped with a write, and chained reads then show whether the one-frame latency is honoured, whether the idle collection frame is used, and whether bytes come back MSB first.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = 2 + ADDR_W + DATA_W;

  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [DATA_W-1:0]  data_t;
  typedef logic [FRAME_W-1:0] frame_t;

  localparam logic DIR_WR  = 1'b0;
  localparam logic DIR_RD  = 1'b1;
  localparam logic DEV_BIT = 1'b0;

  // Serial word: direction first, then device bit, address, data.
  function automatic frame_t make_frame(logic rd, addr_t addr, data_t data);
    return {rd, DEV_BIT, addr, data};
  endfunction
endpackage

// File: rtl/regbus_halfdiv.sv
module regbus_halfdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] limit;

  always_comb begin
    limit  = (half_div_i == '0) ? DIV_W'(1) : half_div_i;
    tick_o = run_i && (cnt_q == limit - DIV_W'(1));
    cnt_d  = (!run_i || tick_o) ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/regbus_gap.sv
module regbus_gap #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             done_o
);
  localparam logic [GAP_W-1:0] CNT_MAX = '1;

  logic [GAP_W-1:0] cnt_q, cnt_d;
  logic [GAP_W-1:0] need;

  always_comb begin
    need   = (gap_i == '0) ? GAP_W'(1) : gap_i;
    done_o = (cnt_q >= need);
    if (restart_i)             cnt_d = GAP_W'(1);
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + GAP_W'(1);
    else                       cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_MAX;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/regbus_shift.sv
module regbus_shift #(
  parameter int FRAME_W = 16,
  parameter int CAP_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               tick_i,
  input  logic               miso_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               sck_o,
  output logic               csn_o,
  output logic               mosi_o,
  output logic [CAP_W-1:0]   rx_o
);
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);
  localparam logic [BIT_W-1:0] CAP_END  = BIT_W'(CAP_W);

  logic               busy_q, busy_d;
  logic               sck_q, sck_d;
  logic [FRAME_W-1:0] tx_q, tx_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic [CAP_W-1:0]   rx_q, rx_d;
  logic               rise, fall, last;

  always_comb begin
    rise   = busy_q && tick_i && !sck_q;
    fall   = busy_q && tick_i && sck_q;
    last   = (bit_q == LAST_BIT);
    done_o = fall && last;

    busy_d = busy_q;
    sck_d  = sck_q;
    tx_d   = tx_q;
    bit_d  = bit_q;
    rx_d   = rx_q;
    if (load_i) begin
      busy_d = 1'b1;
      sck_d  = 1'b0;
      tx_d   = frame_i;
      bit_d  = '0;
      rx_d   = '0;
    end else if (rise) begin
      sck_d = 1'b1;
      if (bit_q < CAP_END) rx_d = {rx_q[CAP_W-2:0], miso_i};
    end else if (fall) begin
      sck_d = 1'b0;
      tx_d  = {tx_q[FRAME_W-2:0], 1'b0};
      if (last) busy_d = 1'b0;
      else      bit_d  = bit_q + BIT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      tx_q   <= '0;
      bit_q  <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sck_q  <= sck_d;
      tx_q   <= tx_d;
      bit_q  <= bit_d;
      rx_q   <= rx_d;
    end
  end

  assign busy_o = busy_q;
  assign sck_o  = sck_q;
  assign csn_o  = ~busy_q;
  assign mosi_o = tx_q[FRAME_W-1];
  assign rx_o   = rx_q;
endmodule

// File: rtl/regbus_master.sv
module regbus_master
  import regbus_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_div_i,
  input  logic [GAP_W-1:0] gap_i,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic             cmd_rd_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  output logic             rsp_valid_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic             ser_clk_o,
  output logic             ser_cs_n_o,
  output logic             ser_mosi_o,
  input  logic             ser_miso_i
);
  logic   busy, gap_done, tick, done;
  data_t  rx;
  logic   accept, start;
  frame_t frame;

  // collection owed from the last completed read frame
  logic  owe_q, owe_d;
  addr_t owe_addr_q, owe_addr_d;
  // current frame collects the byte of an earlier read
  logic  col_q, col_d;
  addr_t col_addr_q, col_addr_d;
  // current frame is a client read that will owe a collection
  logic  new_rd_q, new_rd_d;
  addr_t new_addr_q, new_addr_d;
  logic  rsp_v_q, rsp_v_d;
  addr_t rsp_a_q, rsp_a_d;
  data_t rsp_d_q, rsp_d_d;

  regbus_halfdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run_i(busy), .half_div_i(half_div_i), .tick_o(tick)
  );

  regbus_gap #(.GAP_W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .restart_i(done), .gap_i(gap_i), .done_o(gap_done)
  );

  regbus_shift #(.FRAME_W(FRAME_W), .CAP_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(start), .frame_i(frame), .tick_i(tick),
    .miso_i(ser_miso_i), .busy_o(busy), .done_o(done), .sck_o(ser_clk_o),
    .csn_o(ser_cs_n_o), .mosi_o(ser_mosi_o), .rx_o(rx)
  );

  always_comb begin
    cmd_ready_o = !busy && gap_done;
    accept      = cmd_valid_i && cmd_ready_o;
    start       = accept || (cmd_ready_o && owe_q);
    if (accept)
      frame = make_frame(cmd_rd_i, cmd_addr_i, cmd_rd_i ? data_t'(0) : cmd_wdata_i);
    else
      frame = make_frame(DIR_RD, owe_addr_q, data_t'(0));
  end

  always_comb begin
    owe_d      = owe_q;
    owe_addr_d = owe_addr_q;
    col_d      = col_q;
    col_addr_d = col_addr_q;
    new_rd_d   = new_rd_q;
    new_addr_d = new_addr_q;
    rsp_v_d    = 1'b0;
    rsp_a_d    = rsp_a_q;
    rsp_d_d    = rsp_d_q;
    if (start) begin
      col_d      = owe_q;
      col_addr_d = owe_addr_q;
      new_rd_d   = accept && cmd_rd_i;
      new_addr_d = cmd_addr_i;
      owe_d      = 1'b0;
    end
    if (done) begin
      if (new_rd_q) begin
        owe_d      = 1'b1;
        owe_addr_d = new_addr_q;
      end
      if (col_q) begin
        rsp_v_d = 1'b1;
        rsp_a_d = col_addr_q;
        rsp_d_d = rx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owe_q      <= 1'b0;
      owe_addr_q <= '0;
      col_q      <= 1'b0;
      col_addr_q <= '0;
      new_rd_q   <= 1'b0;
      new_addr_q <= '0;
      rsp_v_q    <= 1'b0;
      rsp_a_q    <= '0;
      rsp_d_q    <= '0;
    end else begin
      owe_q      <= owe_d;
      owe_addr_q <= owe_addr_d;
      col_q      <= col_d;
      col_addr_q <= col_addr_d;
      new_rd_q   <= new_rd_d;
      new_addr_q <= new_addr_d;
      rsp_v_q    <= rsp_v_d;
      rsp_a_q    <= rsp_a_d;
      rsp_d_q    <= rsp_d_d;
    end
  end

  assign rsp_valid_o = rsp_v_q;
  assign rsp_addr_o  = rsp_a_q;
  assign rsp_data_o  = rsp_d_q;
endmodule

// File: rtl/regbus_master_chk.sv
module regbus_master_chk #(
  parameter int GAP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [GAP_W-1:0] gap_i,
  input logic             cmd_ready_o,
  input logic             rsp_valid_o,
  input logic             ser_clk_o,
  input logic             ser_cs_n_o,
  input logic             ser_mosi_o
);
  localparam logic [GAP_W-1:0] HI_MAX = '1;

  logic [GAP_W-1:0] hi_cnt_q;
  logic [GAP_W-1:0] need;

  assign need = (gap_i == '0) ? GAP_W'(1) : gap_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 hi_cnt_q <= HI_MAX;
    else if (!ser_cs_n_o)       hi_cnt_q <= '0;
    else if (hi_cnt_q != HI_MAX) hi_cnt_q <= hi_cnt_q + GAP_W'(1);
  end

  // R9
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_cs_n_o |-> !cmd_ready_o);

  // R7
  clk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk_o |-> !ser_cs_n_o);

  // R3
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk_o |-> $stable(ser_mosi_o));

  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |=> !rsp_valid_o);

  // R10
  rsp_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> $rose(ser_cs_n_o));

  // R8
  gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_cs_n_o) |-> (hi_cnt_q >= need));
endmodule

bind regbus_master regbus_master_chk #(.GAP_W(GAP_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .gap_i(gap_i), .cmd_ready_o(cmd_ready_o),
  .rsp_valid_o(rsp_valid_o), .ser_clk_o(ser_clk_o), .ser_cs_n_o(ser_cs_n_o),
  .ser_mosi_o(ser_mosi_o)
);

// File: tb/regbus_master_tb.sv
module regbus_master_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] half_div = 8'd2;
  logic [7:0] gap = 8'd3;
  logic       cmd_valid = 1'b0;
  logic       cmd_rd = 1'b0;
  logic [5:0] cmd_addr = '0;
  logic [7:0] cmd_wdata = '0;
  logic       cmd_ready, rsp_valid;
  logic [5:0] rsp_addr;
  logic [7:0] rsp_data;
  logic       ser_clk, ser_cs_n, ser_mosi;
  logic       ser_miso = 1'b0;

  always #4 clk = ~clk;

  regbus_master dut_i (
    .clk(clk), .rst_n(rst_n), .half_div_i(half_div), .gap_i(gap),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_rd_i(cmd_rd),
    .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata), .rsp_valid_o(rsp_valid),
    .rsp_addr_o(rsp_addr), .rsp_data_o(rsp_data), .ser_clk_o(ser_clk),
    .ser_cs_n_o(ser_cs_n), .ser_mosi_o(ser_mosi), .ser_miso_i(ser_miso)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- slave model ----------------
  logic [7:0]  sreg [64];
  logic [5:0]  s_prev = '0;
  logic [15:0] s_rx = '0;
  logic [7:0]  s_tx = '0;
  int          s_cnt = 0;
  logic [15:0] flog [64];
  int          nf = 0;

  always @(negedge ser_cs_n) begin
    s_cnt = 0;
    s_rx  = '0;
    s_tx  = sreg[s_prev];
    ser_miso <= s_tx[7];
  end

  always @(posedge ser_clk) begin
    s_rx  = {s_rx[14:0], ser_mosi};
    s_cnt = s_cnt + 1;
    s_tx  = {s_tx[6:0], 1'b0};
    ser_miso <= s_tx[7];
  end

  always @(posedge ser_cs_n) begin
    if (s_cnt == 16) begin
      flog[nf[5:0]] = s_rx;
      nf = nf + 1;
      if (!s_rx[15]) sreg[s_rx[13:8]] = s_rx[7:0];
      s_prev = s_rx[13:8];
      s_cnt  = 0;
    end
  end

  // ---------------- monitors ----------------
  logic [5:0] raddr [16];
  logic [7:0] rdata [16];
  int nr = 0;
  int rsp_multi = 0;
  bit rsp_prev = 0;
  int busy_rdy_bad = 0;
  int gap_rdy_bad = 0;
  int gap_run = 0;
  int gap_min = 1000;
  bit seen_end = 0;
  bit m_cs_prev = 1'b1;
  bit m_clk_prev = 1'b0;
  int run = 0;
  int hi_min = 1000, hi_max = 0, lo_min = 1000, lo_max = 0;
  int eff_gap;
  int idle_clk_bad = 0;

  assign eff_gap = (gap == 0) ? 1 : int'(gap);

  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        raddr[nr[3:0]] = rsp_addr;
        rdata[nr[3:0]] = rsp_data;
        nr = nr + 1;
        if (rsp_prev) rsp_multi++;
      end
      rsp_prev = rsp_valid;

      if (ser_cs_n && !m_cs_prev) seen_end = 1;
      if (ser_cs_n) begin
        gap_run++;
        if (ser_clk) idle_clk_bad++;
        if (seen_end && (cmd_ready !== (gap_run >= eff_gap))) gap_rdy_bad++;
      end else begin
        if (cmd_ready) busy_rdy_bad++;
        if (m_cs_prev && seen_end && gap_run < gap_min) gap_min = gap_run;
        gap_run = 0;
      end

      if (!ser_cs_n && !m_cs_prev && ser_clk == m_clk_prev) run++;
      else begin
        if (!m_cs_prev) begin
          if (m_clk_prev) begin
            if (run < hi_min) hi_min = run;
            if (run > hi_max) hi_max = run;
          end else begin
            if (run < lo_min) lo_min = run;
            if (run > lo_max) lo_max = run;
          end
        end
        run = 1;
      end
      m_clk_prev = ser_clk;
      m_cs_prev  = ser_cs_n;
    end
  end

  // ---------------- helpers ----------------
  task automatic clear_stats();
    nf = 0; nr = 0;
    hi_min = 1000; hi_max = 0; lo_min = 1000; lo_max = 0;
    gap_min = 1000;
  endtask

  task automatic send(bit rd, logic [5:0] a, logic [7:0] d);
    cmd_valid = 1'b1; cmd_rd = rd; cmd_addr = a; cmd_wdata = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_frames(int k);
    int h;
    h = (half_div == 0) ? 1 : int'(half_div);
    repeat (k * (32 * h + eff_gap + 8)) @(negedge clk);
  endtask

  task automatic check_widths(string req, int h);
    chk(hi_min == h && hi_max == h, req, "serial clock high half", hi_max, h);
    chk(lo_min == h && lo_max == h, req, "serial clock low half", lo_max, h);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(ser_cs_n == 1'b1, "R1", "chip select after reset", int'(ser_cs_n), 1);
    chk(ser_clk == 1'b0, "R1", "serial clock after reset", int'(ser_clk), 0);
    chk(cmd_ready == 1'b1, "R1", "ready after reset", int'(cmd_ready), 1);
    chk(rsp_valid == 1'b0, "R1", "response after reset", int'(rsp_valid), 0);
  endtask

  task automatic t_write();
    half_div = 8'd2; gap = 8'd3;
    @(negedge clk); clear_stats();
    send(1'b0, 6'd5, 8'hA5);
    wait_frames(3);
    chk(nf == 1, "R11", "frames for a lone write", nf, 1);
    chk(flog[0] == 16'h05A5, "R2", "write frame layout", int'(flog[0]), 16'h05A5);
    chk(sreg[5] == 8'hA5, "R3", "slave register after write", int'(sreg[5]), 8'hA5);
    chk(nr == 0, "R11", "responses after a write", nr, 0);
    check_widths("R7", 2);
  endtask

  task automatic t_read_alone();
    @(negedge clk); clear_stats();
    send(1'b1, 6'd5, 8'h3C);
    wait_frames(4);
    chk(nf == 2, "R4", "frames for an isolated read", nf, 2);
    chk(flog[0] == 16'h8500, "R2", "read frame layout", int'(flog[0]), 16'h8500);
    chk(flog[1] == 16'h8500, "R5", "idle collection frame", int'(flog[1]), 16'h8500);
    chk(nr == 1, "R5", "single response", nr, 1);
    chk(raddr[0] == 6'd5, "R4", "response address", int'(raddr[0]), 5);
    chk(rdata[0] == 8'hA5, "R4", "response data", int'(rdata[0]), 8'hA5);
  endtask

  task automatic t_overlap();
    @(negedge clk);
    send(1'b0, 6'd9, 8'h5A);
    wait_frames(2);
    clear_stats();
    send(1'b1, 6'd9, 8'h00);
    send(1'b0, 6'd10, 8'hC3);
    wait_frames(4);
    chk(nf == 2, "R6", "frames for read plus queued write", nf, 2);
    chk(flog[1] == 16'h0AC3, "R6", "queued write as collection frame", int'(flog[1]), 16'h0AC3);
    chk(sreg[10] == 8'hC3, "R6", "queued write took effect", int'(sreg[10]), 8'hC3);
    chk(nr == 1 && rdata[0] == 8'h5A, "R4", "overlapped read data", int'(rdata[0]), 8'h5A);
    chk(raddr[0] == 6'd9, "R4", "overlapped read address", int'(raddr[0]), 9);
    chk(gap_min == 3, "R8", "gap with command waiting", gap_min, 3);
  endtask

  task automatic t_chain();
    half_div = 8'd1; gap = 8'd0;
    @(negedge clk); clear_stats();
    send(1'b1, 6'd3, 8'h00);
    send(1'b1, 6'd4, 8'h00);
    wait_frames(5);
    chk(nf == 3, "R5", "frames for two chained reads", nf, 3);
    chk(flog[2] == 16'h8400, "R5", "idle collection of last read", int'(flog[2]), 16'h8400);
    chk(nr == 2, "R4", "responses for chained reads", nr, 2);
    chk(raddr[0] == 6'd3 && rdata[0] == 8'h18, "R4", "first chained response", int'(rdata[0]), 8'h18);
    chk(raddr[1] == 6'd4 && rdata[1] == 8'h1F, "R4", "second chained response", int'(rdata[1]), 8'h1F);
    check_widths("R7", 1);
    chk(gap_min == 1, "R8", "zero gap setting acts as one", gap_min, 1);
  endtask

  task automatic t_slow();
    half_div = 8'd4; gap = 8'd7;
    @(negedge clk); clear_stats();
    send(1'b0, 6'd20, 8'h81);
    send(1'b1, 6'd20, 8'h00);
    wait_frames(5);
    chk(nf == 3, "R5", "frames for write then read", nf, 3);
    chk(nr == 1 && rdata[0] == 8'h81, "R4", "MSB-first byte capture", int'(rdata[0]), 8'h81);
    check_widths("R7", 4);
    chk(gap_min == 7, "R8", "gap of seven clocks", gap_min, 7);
  endtask

  task automatic t_monitors();
    chk(busy_rdy_bad == 0, "R9", "ready during frame", busy_rdy_bad, 0);
    chk(gap_rdy_bad == 0, "R9", "ready during gap", gap_rdy_bad, 0);
    chk(rsp_multi == 0, "R10", "response longer than one cycle", rsp_multi, 0);
    chk(idle_clk_bad == 0, "R7", "serial clock high while deselected", idle_clk_bad, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) sreg[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_read_alone();
    t_overlap();
    t_chain();
    t_slow();
    t_monitors();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule